// File: doc/BRIEF.md
# Four-Channel Expansion Bus DMA Controller

This block moves blocks of 32-bit words between a system address range and an external address range. It has four channels with the same register layout. Software sets a channel's addresses, byte length and direction, then arms it by writing two separate one-bit control registers. A channel starts only when both bits are one. The copy runs over a single-beat memory port as a read of one word followed by a write of that word. When the last word has been written, the second control bit clears and the channel sends a one-cycle completion event.

Only one transfer runs at a time. Channels that are waiting are served lowest-numbered first. The values in a channel's registers are copied into working counters when the channel is granted. Software can therefore reprogram a running channel for its next transfer without disturbing the current one.

Top module: `xbus_dma`

## Requirements
- R1: After reset, every register reads zero, `memReq` is low and `doneEvt` is zero.
- R2: `regAddr` is a word index. Bits [4:3] select the channel, and each channel's bank spans 8 words (32 bytes). Bits [2:0] select the register: 0 external address, 1 system address, 2 length, 3 direction, 4 mode, 5 control A, 6 control B, 7 stop. A write changes only the addressed register, and reads return the stored value.
- R3: Stored values are the written data masked as follows. External address, system address and length use 0x9FFFFFE0. Mode uses 0x7, direction and both controls use 0x1, and stop uses 0x37.
- R4: A write to either control register that leaves both control A and control B at one queues that channel for a transfer.
- R5: A control write that leaves control A at one and control B at zero drops any queued start, and no transfer or event follows. While control A is zero, setting control B stores it but starts nothing until control A is written to one.
- R6: With direction 0, word k is read from system address + 4k and written to external address + 4k. With direction 1, the copy runs from the external address to the system address. Each word is one read beat followed by one write beat that carries the data just read.
- R7: The word count is (length & 0x1FFFFFFF) >> 2. A count of zero makes no memory beats but still completes with an event.
- R8: After the last write beat, `doneEvt` bit c pulses high for exactly one cycle, at most one bit is high at a time, and control B of channel c then reads zero.
- R9: A memory request holds its address, direction and write data unchanged until `memReady` is high.
- R10: Waiting channels are granted lowest number first, one transfer at a time. No request is made in the cycle of a completion event.
- R11: Register writes to a running channel are stored and read back at once, but the running transfer keeps the values captured at grant. The new values are used for the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register word index (channel, register) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| memReq | output | 1 | Memory beat request |
| memWe | output | 1 | 1 = write beat, 0 = read beat |
| memAddr | output | 32 | Memory byte address |
| memWData | output | 32 | Memory write data |
| memRData | input | 32 | Memory read data, valid when `memReady` |
| memReady | input | 1 | Beat completes at the clock edge where this is high |
| doneEvt | output | 4 | Per-channel one-cycle completion event |

## Verification
- **Register writes:** a register write lands at the rising edge where `regWrEn` is high, and the read port shows the new value right after that edge.
- **Arming and grant:** a control write that arms a channel sets its queued flag at that same edge. The grant happens at the next edge, and the first read request appears in the cycle after the grant.
- **Completion:** the completion event is high in the cycle after the final write handshake, and control B reads zero from the following cycle.
- **How the bench samples:** it drives inputs and samples outputs one nanosecond after the falling edge. It logs every write handshake and event as it happens. It compares the log with the computed sequence only after waiting for the event plus a few spare cycles, so no check depends on the exact beat count.

// File: rtl/xbus_dma_pkg.sv
package xbus_dma_pkg;

  localparam int DATA_W     = 32;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int LEN_BITS   = 29;
  localparam int WCNT_W     = LEN_BITS - 2;

  localparam logic [2:0] REG_EXT  = 3'd0;
  localparam logic [2:0] REG_SYS  = 3'd1;
  localparam logic [2:0] REG_LEN  = 3'd2;
  localparam logic [2:0] REG_DIR  = 3'd3;
  localparam logic [2:0] REG_MODE = 3'd4;
  localparam logic [2:0] REG_CTLA = 3'd5;
  localparam logic [2:0] REG_CTLB = 3'd6;
  localparam logic [2:0] REG_STOP = 3'd7;

  localparam logic [DATA_W-1:0] ADDR_MASK = 32'h9FFF_FFE0;
  localparam logic [5:0]        STOP_MASK = 6'h37;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } xferState_t;

  typedef struct packed {
    logic load;     // capture selected channel setup into working counters
    logic capture;  // latch read data
    logic advance;  // step addresses and count after a write beat
  } dpStrobe_t;

endpackage

// File: rtl/xbus_dma_regs.sv
module xbus_dma_regs
  import xbus_dma_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RA_W = CH_W + 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [RA_W-1:0]                regAddr,
  input  logic [DATA_W-1:0]              wrData,
  output logic [DATA_W-1:0]              rdData,
  input  logic                           clrCtlB,
  input  logic [CH_W-1:0]                clrCh,
  input  logic                           grantEn,
  input  logic [CH_W-1:0]                grantCh,
  input  logic                           busy,
  input  logic [CH_W-1:0]                activeCh,
  output logic [NUM_CH-1:0]              pending,
  output logic [NUM_CH-1:0][DATA_W-1:0]  extQ,
  output logic [NUM_CH-1:0][DATA_W-1:0]  sysQ,
  output logic [NUM_CH-1:0][WCNT_W-1:0]  wordsQ,
  output logic [NUM_CH-1:0]              dirQ
);

  logic [CH_W-1:0] chSel;
  logic [2:0]      regSel;
  logic [NUM_CH-1:0][DATA_W-1:0] chRd;

  assign chSel  = regAddr[RA_W-1:3];
  assign regSel = regAddr[2:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] extR, sysR, lenR;
    logic              dirR, ctlAR, ctlBR, pendR;
    logic [2:0]        modeR;
    logic [5:0]        stopR;
    logic              hit, ctlHit, nxtA, nxtB, selfActive;

    assign hit        = wrEn && (chSel == CH_W'(c));
    assign ctlHit     = hit && ((regSel == REG_CTLA) || (regSel == REG_CTLB));
    assign nxtA       = (regSel == REG_CTLA) ? wrData[0] : ctlAR;
    assign nxtB       = (regSel == REG_CTLB) ? wrData[0] : ctlBR;
    assign selfActive = busy && (activeCh == CH_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        extR  <= '0;
        sysR  <= '0;
        lenR  <= '0;
        dirR  <= 1'b0;
        modeR <= '0;
        stopR <= '0;
        ctlAR <= 1'b0;
        ctlBR <= 1'b0;
        pendR <= 1'b0;
      end else begin
        if (hit) begin
          case (regSel)
            REG_EXT:  extR  <= wrData & ADDR_MASK;
            REG_SYS:  sysR  <= wrData & ADDR_MASK;
            REG_LEN:  lenR  <= wrData & ADDR_MASK;
            REG_DIR:  dirR  <= wrData[0];
            REG_MODE: modeR <= wrData[2:0];
            REG_CTLA: ctlAR <= wrData[0];
            REG_CTLB: ctlBR <= wrData[0];
            default:  stopR <= wrData[5:0] & STOP_MASK;
          endcase
        end
        if (clrCtlB && (clrCh == CH_W'(c))) ctlBR <= 1'b0;
        if (grantEn && (grantCh == CH_W'(c))) pendR <= 1'b0;
        if (ctlHit && nxtA) begin
          if (!nxtB)            pendR <= 1'b0;
          else if (!selfActive) pendR <= 1'b1;
        end
      end
    end

    always_comb begin
      case (regSel)
        REG_EXT:  chRd[c] = extR;
        REG_SYS:  chRd[c] = sysR;
        REG_LEN:  chRd[c] = lenR;
        REG_DIR:  chRd[c] = {{(DATA_W-1){1'b0}}, dirR};
        REG_MODE: chRd[c] = {{(DATA_W-3){1'b0}}, modeR};
        REG_CTLA: chRd[c] = {{(DATA_W-1){1'b0}}, ctlAR};
        REG_CTLB: chRd[c] = {{(DATA_W-1){1'b0}}, ctlBR};
        default:  chRd[c] = {{(DATA_W-6){1'b0}}, stopR};
      endcase
    end

    assign pending[c] = pendR;
    assign extQ[c]    = extR;
    assign sysQ[c]    = sysR;
    assign wordsQ[c]  = lenR[LEN_BITS-1:2];
    assign dirQ[c]    = dirR;
  end

  assign rdData = chRd[chSel];

endmodule

// File: rtl/xbus_dma_arb.sv
module xbus_dma_arb #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req,
  output logic              reqAny,
  output logic [CH_W-1:0]   reqIdx
);

  // Fixed priority: lowest index wins, so scan from the top down.
  always_comb begin
    reqIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) reqIdx = CH_W'(i);
    end
  end

  assign reqAny = |req;

endmodule

// File: rtl/xbus_dma_ctrl.sv
module xbus_dma_ctrl
  import xbus_dma_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqAny,
  input  logic [CH_W-1:0]   reqIdx,
  input  logic              wordsZero,
  input  logic              lastWord,
  input  logic              memReady,
  output logic              grantEn,
  output logic [CH_W-1:0]   curCh,
  output logic              busy,
  output dpStrobe_t         strobe,
  output logic              memReq,
  output logic              memWe,
  output logic [NUM_CH-1:0] doneEvt,
  output logic              clrCtlB
);

  xferState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      curCh <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqAny) begin
            curCh <= reqIdx;
            state <= wordsZero ? ST_DONE : ST_READ;
          end
        end
        ST_READ:  if (memReady) state <= ST_WRITE;
        ST_WRITE: if (memReady) state <= lastWord ? ST_DONE : ST_READ;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    grantEn        = (state == ST_IDLE) && reqAny;
    strobe.load    = grantEn;
    strobe.capture = (state == ST_READ) && memReady;
    strobe.advance = (state == ST_WRITE) && memReady;
    memReq         = (state == ST_READ) || (state == ST_WRITE);
    memWe          = (state == ST_WRITE);
    clrCtlB        = (state == ST_DONE);
    busy           = (state != ST_IDLE);
    doneEvt        = (state == ST_DONE) ? (NUM_CH'(1) << curCh) : '0;
  end

endmodule

// File: rtl/xbus_dma_dp.sv
module xbus_dma_dp
  import xbus_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] selExt,
  input  logic [DATA_W-1:0] selSys,
  input  logic [WCNT_W-1:0] selWords,
  input  logic              selDir,
  input  logic              memWe,
  input  logic [DATA_W-1:0] memRData,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic              wordsZero,
  output logic              lastWord
);

  logic [DATA_W-1:0] srcA, dstA, bufQ;
  logic [WCNT_W-1:0] leftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcA  <= '0;
      dstA  <= '0;
      bufQ  <= '0;
      leftQ <= '0;
    end else begin
      if (strobe.load) begin
        srcA  <= selDir ? selExt : selSys;
        dstA  <= selDir ? selSys : selExt;
        leftQ <= selWords;
      end
      if (strobe.capture) bufQ <= memRData;
      if (strobe.advance) begin
        srcA  <= srcA + DATA_W'(WORD_BYTES);
        dstA  <= dstA + DATA_W'(WORD_BYTES);
        leftQ <= leftQ - WCNT_W'(1);
      end
    end
  end

  assign memAddr   = memWe ? dstA : srcA;
  assign memWData  = bufQ;
  assign wordsZero = (selWords == '0);
  assign lastWord  = (leftQ == WCNT_W'(1));

endmodule

// File: rtl/xbus_dma.sv
module xbus_dma
  import xbus_dma_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RA_W = CH_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memReq,
  output logic              memWe,
  output logic [31:0]       memAddr,
  output logic [31:0]       memWData,
  input  logic [31:0]       memRData,
  input  logic              memReady,
  output logic [NUM_CH-1:0] doneEvt
);

  logic [NUM_CH-1:0]             pending, dirQ;
  logic [NUM_CH-1:0][DATA_W-1:0] extQ, sysQ;
  logic [NUM_CH-1:0][WCNT_W-1:0] wordsQ;
  logic                          reqAny, grantEn, busy, clrCtlB;
  logic                          wordsZero, lastWord;
  logic [CH_W-1:0]               reqIdx, curCh;
  dpStrobe_t                     strobe;

  xbus_dma_regs #(.NUM_CH(NUM_CH)) regs_i (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .regAddr(regAddr),
    .wrData(regWrData), .rdData(regRdData),
    .clrCtlB(clrCtlB), .clrCh(curCh),
    .grantEn(grantEn), .grantCh(reqIdx),
    .busy(busy), .activeCh(curCh),
    .pending(pending), .extQ(extQ), .sysQ(sysQ), .wordsQ(wordsQ), .dirQ(dirQ)
  );

  xbus_dma_arb #(.NUM_CH(NUM_CH)) arb_i (
    .req(pending), .reqAny(reqAny), .reqIdx(reqIdx)
  );

  xbus_dma_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqAny(reqAny), .reqIdx(reqIdx),
    .wordsZero(wordsZero), .lastWord(lastWord), .memReady(memReady),
    .grantEn(grantEn), .curCh(curCh), .busy(busy), .strobe(strobe),
    .memReq(memReq), .memWe(memWe), .doneEvt(doneEvt), .clrCtlB(clrCtlB)
  );

  xbus_dma_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .selExt(extQ[reqIdx]), .selSys(sysQ[reqIdx]),
    .selWords(wordsQ[reqIdx]), .selDir(dirQ[reqIdx]),
    .memWe(memWe), .memRData(memRData),
    .memAddr(memAddr), .memWData(memWData),
    .wordsZero(wordsZero), .lastWord(lastWord)
  );

endmodule

// File: rtl/xbus_dma_chk.sv
module xbus_dma_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic [31:0]       memAddr,
  input logic [31:0]       memWData,
  input logic [31:0]       memRData,
  input logic              memReady,
  input logic [NUM_CH-1:0] doneEvt
);

  logic [31:0] rdBuf;
  logic        seenRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBuf  <= '0;
      seenRd <= 1'b0;
    end else if (memReq && memReady) begin
      if (!memWe) begin
        rdBuf  <= memRData;
        seenRd <= 1'b1;
      end else begin
        seenRd <= 1'b0;
      end
    end
  end

  assert_quiet_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!memReq && (doneEvt == '0)));

  assert_copy_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memReady) |-> (seenRd && (memWData == rdBuf)));

  assert_done_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(doneEvt));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    (doneEvt != '0) |=> (doneEvt == '0));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=>
      (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWData)));

  assert_single_xfer_R10: assert property (@(posedge clk) disable iff (!rstN)
    (doneEvt != '0) |-> !memReq);

endmodule

bind xbus_dma xbus_dma_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memWData(memWData), .memRData(memRData),
  .memReady(memReady), .doneEvt(doneEvt)
);

// File: tb/xbus_dma_tb.sv
module xbus_dma_tb_top;
  import xbus_dma_pkg::*;

  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWData, memRData;
  logic        memReady = 1'b1;
  logic [3:0]  doneEvt;

  always #2 clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  assign memRData = pat(memAddr);

  xbus_dma #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData), .memReady(memReady), .doneEvt(doneEvt)
  );

  int errCnt = 0, chkCnt = 0, cyc = 0, stallMode = 0;
  int wrCnt = 0, doneCnt = 0, expCnt = 0;
  logic [31:0] logAddr [128];
  logic [31:0] logData [128];
  logic [31:0] expAddr [128];
  logic [31:0] expData [128];
  int          doneLog [8];
  logic [31:0] model [NCH][8];

  // Beat and event monitor, sampled after the falling edge
  always @(negedge clk) begin
    cyc++;
    memReady = (stallMode == 0) || ((cyc % 3) != 0);
    #1;
    if (rstN) begin
      if (memReq && memReady && memWe) begin
        if (wrCnt < 128) begin
          logAddr[wrCnt] = memAddr;
          logData[wrCnt] = memWData;
        end
        wrCnt++;
      end
      for (int c = 0; c < NCH; c++) begin
        if (doneEvt[c]) begin
          if (doneCnt < 8) doneLog[doneCnt] = c;
          doneCnt++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] maskOf(input logic [2:0] r);
    case (r)
      REG_EXT, REG_SYS, REG_LEN: return ADDR_MASK;
      REG_MODE:                  return 32'h7;
      REG_STOP:                  return 32'h37;
      default:                   return 32'h1;
    endcase
  endfunction

  task automatic wr(input int ch, input logic [2:0] r, input logic [31:0] v);
    @(negedge clk);
    regWrEn   = 1'b1;
    regAddr   = {2'(ch), r};
    regWrData = v;
    @(negedge clk);
    regWrEn   = 1'b0;
    model[ch][r] = v & maskOf(r);
  endtask

  task automatic rd(input int ch, input logic [2:0] r, output logic [31:0] v);
    @(negedge clk);
    regAddr = {2'(ch), r};
    #1;
    v = regRdData;
  endtask

  task automatic clearLogs();
    wrCnt = 0; doneCnt = 0; expCnt = 0;
  endtask

  task automatic addExp(input int ch);
    logic [31:0] s, d;
    int n;
    s = model[ch][REG_DIR][0] ? model[ch][REG_EXT] : model[ch][REG_SYS];
    d = model[ch][REG_DIR][0] ? model[ch][REG_SYS] : model[ch][REG_EXT];
    n = int'((model[ch][REG_LEN] & 32'h1FFF_FFFF) >> 2);
    for (int k = 0; k < n; k++) begin
      if (expCnt < 128) begin
        expAddr[expCnt] = d + 32'(4 * k);
        expData[expCnt] = pat(s + 32'(4 * k));
      end
      expCnt++;
    end
  endtask

  task automatic waitDone(input int n, input string tag);
    int t = 0;
    while (doneCnt < n && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    chk(doneCnt == n, tag, 32'(doneCnt), 32'(n));
  endtask

  task automatic compareLog(input string tag);
    chk(wrCnt == expCnt, {tag, " beat count"}, 32'(wrCnt), 32'(expCnt));
    for (int k = 0; k < expCnt && k < wrCnt && k < 128; k++) begin
      chk(logAddr[k] == expAddr[k], {tag, " write addr"}, logAddr[k], expAddr[k]);
      chk(logData[k] == expData[k], {tag, " write data"}, logData[k], expData[k]);
    end
  endtask

  task automatic runXfer(input int ch, input bit dir, input logic [31:0] ext,
                         input logic [31:0] sys, input logic [31:0] len, input int stall);
    logic [31:0] v;
    stallMode = stall;
    wr(ch, REG_EXT, ext);
    wr(ch, REG_SYS, sys);
    wr(ch, REG_LEN, len);
    wr(ch, REG_DIR, {31'b0, dir});
    wr(ch, REG_CTLA, 32'h1);
    clearLogs();
    addExp(ch);
    wr(ch, REG_CTLB, 32'h1);
    waitDone(1, "R4 start/complete");
    compareLog(dir ? "R6 dir1" : "R6 dir0");
    chk(doneLog[0] == ch, "R8 event channel", 32'(doneLog[0]), 32'(ch));
    rd(ch, REG_CTLB, v);
    chk(v == 32'h0, "R8 control B cleared", v, 32'h0);
    model[ch][REG_CTLB] = 32'h0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errCnt++; chkCnt++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 8; r++) model[c][r] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    #1;
    chk(memReq == 1'b0, "R1 memReq idle", 32'(memReq), 32'h0);
    chk(doneEvt == 4'h0, "R1 no event", 32'(doneEvt), 32'h0);
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 8; r++) begin
        rd(c, 3'(r), v);
        chk(v == 32'h0, "R1 reset register", v, 32'h0);
      end

    // R2/R3/R5: register sweep across every channel
    for (int c = 0; c < NCH; c++) begin
      for (int r = 0; r < 8; r++) begin
        if (r == 5 || r == 6) continue;
        wr(c, 3'(r), 32'hFFFF_FFFF);
        rd(c, 3'(r), v);
        chk(v == maskOf(3'(r)), "R3 write mask", v, maskOf(3'(r)));
        wr(c, 3'(r), 32'h1357_9BDF ^ (32'(c) * 32'h0102_0304) ^ (32'(r) * 32'h1020_3040));
      end
      wr(c, REG_CTLB, 32'hFFFF_FFFF);
      rd(c, REG_CTLB, v);
      chk(v == 32'h1, "R5 control B stored with A clear", v, 32'h1);
      wr(c, REG_CTLB, 32'hFFFF_FFFE);
      wr(c, REG_CTLA, 32'hFFFF_FFFF);
      rd(c, REG_CTLA, v);
      chk(v == 32'h1, "R3 control A mask", v, 32'h1);
      wr(c, REG_CTLA, 32'h0);
    end
    repeat (10) @(negedge clk);
    chk(wrCnt == 0, "R5 no beats during sweep", 32'(wrCnt), 32'h0);
    chk(doneCnt == 0, "R5 no events during sweep", 32'(doneCnt), 32'h0);
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 8; r++) begin
        rd(c, 3'(r), v);
        chk(v == model[c][r], "R2 register isolation", v, model[c][r]);
      end

    // R4/R6/R7/R8: transfers on every channel, both directions
    runXfer(0, 1'b0, 32'h8000_1000, 32'h0C00_0000, 32'h0000_0040, 0);
    runXfer(1, 1'b1, 32'h8000_1100, 32'h0C00_0200, 32'h8000_0020, 1);
    runXfer(2, 1'b0, 32'h8000_1200, 32'h0C00_0400, 32'h0000_003F, 1); // R7 rounds to 8 words
    runXfer(3, 1'b1, 32'h8000_1300, 32'h0C00_0600, 32'h0000_001F, 0); // R7 zero words
    runXfer(2, 1'b1, 32'h1FFF_FFE0, 32'h0000_0020, 32'h0000_0060, 1);

    // R5: A=1,B=0 cancels; B=1 with A=0 waits for A
    stallMode = 0;
    wr(1, REG_CTLB, 32'h0);
    clearLogs();
    wr(1, REG_CTLA, 32'h1);
    repeat (20) @(negedge clk);
    chk(wrCnt == 0 && doneCnt == 0, "R5 cancel gives no transfer", 32'(wrCnt + doneCnt), 32'h0);
    wr(1, REG_CTLA, 32'h0);
    wr(1, REG_CTLB, 32'h1);
    repeat (20) @(negedge clk);
    chk(wrCnt == 0 && doneCnt == 0, "R5 B without A gives no transfer", 32'(wrCnt + doneCnt), 32'h0);
    addExp(1);
    wr(1, REG_CTLA, 32'h1);
    waitDone(1, "R4 start by control A");
    compareLog("R4 start by control A");
    model[1][REG_CTLB] = 32'h0;

    // R5: a queued start withdrawn while another channel is busy
    stallMode = 1;
    wr(3, REG_LEN, 32'h40);
    clearLogs();
    addExp(3);
    wr(3, REG_CTLB, 32'h1);
    wr(1, REG_CTLB, 32'h1);
    wr(1, REG_CTLB, 32'h0);
    waitDone(1, "R5 queued cancel");
    repeat (20) @(negedge clk);
    chk(doneCnt == 1, "R5 withdrawn channel stays idle", 32'(doneCnt), 32'h1);
    chk(doneLog[0] == 3, "R5 only busy channel completed", 32'(doneLog[0]), 32'h3);
    compareLog("R5 queued cancel");
    model[3][REG_CTLB] = 32'h0;

    // R10/R11: fixed priority and shadowed setup
    wr(0, REG_LEN, 32'h20);
    wr(2, REG_LEN, 32'h20);
    clearLogs();
    addExp(3);
    addExp(0);
    addExp(2);
    wr(3, REG_CTLB, 32'h1);
    wr(2, REG_CTLB, 32'h1);
    wr(0, REG_CTLB, 32'h1);
    wr(3, REG_LEN, 32'h20);
    rd(3, REG_LEN, v);
    chk(v == 32'h20, "R11 write to busy channel visible", v, 32'h20);
    waitDone(3, "R10 three completions");
    chk(doneLog[0] == 3, "R10 running channel first", 32'(doneLog[0]), 32'h3);
    chk(doneLog[1] == 0, "R10 lowest waiting next", 32'(doneLog[1]), 32'h0);
    chk(doneLog[2] == 2, "R10 higher waiting last", 32'(doneLog[2]), 32'h2);
    compareLog("R11 running transfer unchanged");
    model[0][REG_CTLB] = 32'h0;
    model[2][REG_CTLB] = 32'h0;
    model[3][REG_CTLB] = 32'h0;
    clearLogs();
    addExp(3);
    wr(3, REG_CTLB, 32'h1);
    waitDone(1, "R11 new length used");
    compareLog("R11 new length used");

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule